// File: doc/BRIEF.md
# Preloadable Down-Counter / Timer

This block is a down-counter whose start value comes from a preload register. Software assembles the preload from an upper byte and a lower byte, each with its own write strobe. A configuration write picks the operating mode and one of several clock-enable inputs as the counting source. Each pulse on the selected enable moves the counter by one.

In timer mode the counter never stops. Each time it reaches terminal count it reloads from the preload, toggles a square-wave output and raises the ready flag, so the block acts as a programmable divider. In counter mode a start strobe (a read access on the bus side) loads the preload and begins counting down. A stop strobe halts the counter, and the count then becomes visible on the read-back port. The step from 1 to 0 raises the ready flag. The output pin carries the square wave in timer mode and an active-low copy of the ready flag in counter mode. After reset the block runs free in timer mode.

Top module: `cdt_top`

## Requirements
- R1: After synchronous reset the block is in timer mode with source 0, the preload is all ones, `rdy_o` is 0, `pin_o` is 1 and `count_o` is 0.
- R2: `pre_hi_we` loads `pre_byte` into the upper byte of the preload, and `pre_lo_we` loads it into the lower byte. The preload may be rewritten at any time and is used only at the next load. A rewrite leaves the current count unchanged.
- R3: In counter mode `start_rd` loads the preload into the counter and sets it running. Each cycle after that with the selected tick high decrements the count by one. A tick in the same cycle as `start_rd` is not counted.
- R4: In counter mode a decrement from 1 to 0 sets `rdy_o` one cycle later. Counting continues and wraps from 0 to all ones.
- R5: `stop_rd` halts the counter in counter mode. `count_o` shows the count only while counter mode is stopped. While running, and in timer mode, `count_o` reads 0.
- R6: In timer mode `start_rd` and `stop_rd` never halt counting. On a tick with count 1 (or 0), the counter reloads from the preload, the square wave toggles and `rdy_o` is set. With a tick every cycle, `pin_o` therefore changes every `preload` cycles.
- R7: `stop_rd` clears `rdy_o` in both modes.
- R8: `cfg_src` selects which bit of `src_tick` is the counting source (value k selects bit k). Pulses on the other bits have no effect.
- R9: `pin_o` equals the square wave in timer mode and equals `~rdy_o` in counter mode.
- R10: `cfg_we` stores `cfg_mode` (0 = timer, 1 = counter) and `cfg_src`. It also loads the count from the preload, stops the counter, clears `rdy_o` and sets the square wave high.
- R11: When `stop_rd` and `start_rd` arrive in the same cycle, stop wins and nothing is loaded. A tick in the same cycle as `stop_rd` is not counted, so the ready flag is not set by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | N_SRC | Clock-enable pulses, one per possible source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | Mode written by `cfg_we`: 0 timer, 1 counter |
| cfg_src | input | SEL_W | Source index written by `cfg_we` |
| pre_hi_we | input | 1 | Write strobe for the preload upper byte |
| pre_lo_we | input | 1 | Write strobe for the preload lower byte |
| pre_byte | input | CNT_W/2 | Byte written into the preload |
| start_rd | input | 1 | Start strobe (counter mode) |
| stop_rd | input | 1 | Stop strobe, also clears the ready flag |
| count_o | output | CNT_W | Count read-back, valid while stopped in counter mode |
| rdy_o | output | 1 | Ready flag |
| pin_o | output | 1 | Square wave (timer) or active-low ready (counter) |

## Verification
The bench uses the defaults: CNT_W of 16 and four clock-enable sources. It writes small preloads such as 2, 3, 5 and 9, so terminal count, reload and the square-wave period all occur within a few dozen cycles. The wrap from 0 to 0xFFFF is reached with one tick past terminal. All four source positions can be selected. This lets the bench show that a pulse on an unselected source does not move the count, and that a rewritten preload takes effect only at the next start.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_COUNT = 1'b1
  } cdt_mode_e;
endpackage

// File: rtl/cdt_src_mux.sv
module cdt_src_mux #(
  parameter int N_SRC = 4,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel_i == SEL_W'(k)) tick_o = tick_i[k];
    end
  end
endmodule

// File: rtl/cdt_preload.sv
module cdt_preload #(
  parameter int CNT_W = 16,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] byte_i,
  output logic [CNT_W-1:0]  preload_o
);
  logic [HALF_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '1;
      lo_q <= '1;
    end else begin
      if (hi_we) hi_q <= byte_i;
      if (lo_we) lo_q <= byte_i;
    end
  end

  assign preload_o = {hi_q, lo_q};
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_we,
  input  cdt_mode_e        cfg_mode,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             rdy_q,
  output logic             sq_q,
  output cdt_mode_e        mode_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_term;
  assign at_term = (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_TIMER;
      cnt_q  <= '1;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      sq_q   <= 1'b1;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      cnt_q  <= preload;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      sq_q   <= 1'b1;
    end else if (mode_q == MODE_TIMER) begin
      if (tick) begin
        if (at_term) begin
          cnt_q <= preload;
          sq_q  <= ~sq_q;
          rdy_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      if (stop) rdy_q <= 1'b0;
    end else begin
      if (stop) begin
        run_q <= 1'b0;
        rdy_q <= 1'b0;
      end else if (start) begin
        cnt_q <= preload;
        run_q <= 1'b1;
      end else if (run_q && tick) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) rdy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SRC = 4,
  localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_tick,
  input  logic              cfg_we,
  input  logic              cfg_mode,
  input  logic [SEL_W-1:0]  cfg_src,
  input  logic              pre_hi_we,
  input  logic              pre_lo_we,
  input  logic [HALF_W-1:0] pre_byte,
  input  logic              start_rd,
  input  logic              stop_rd,
  output logic [CNT_W-1:0]  count_o,
  output logic              rdy_o,
  output logic              pin_o
);
  logic [SEL_W-1:0] src_q;
  logic             tick;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, rdy_q, sq_q;
  cdt_mode_e        mode_q;

  always_ff @(posedge clk) begin
    if (rst)         src_q <= '0;
    else if (cfg_we) src_q <= cfg_src;
  end

  cdt_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
    .tick_i(src_tick), .sel_i(src_q), .tick_o(tick)
  );

  cdt_preload #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .hi_we(pre_hi_we), .lo_we(pre_lo_we),
    .byte_i(pre_byte), .preload_o(preload)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .start(start_rd), .stop(stop_rd),
    .cfg_we(cfg_we), .cfg_mode(cdt_mode_e'(cfg_mode)), .preload(preload),
    .cnt_q(cnt_q), .run_q(run_q), .rdy_q(rdy_q), .sq_q(sq_q), .mode_q(mode_q)
  );

  assign rdy_o   = rdy_q;
  assign pin_o   = (mode_q == MODE_COUNT) ? ~rdy_q : sq_q;
  assign count_o = (mode_q == MODE_COUNT && !run_q) ? cnt_q : '0;
endmodule

// File: rtl/cdt_top_chk.sv
module cdt_top_chk #(
  parameter int CNT_W = 16,
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] src_tick,
  input logic             cfg_we,
  input logic             cfg_mode,
  input logic             start_rd,
  input logic             stop_rd,
  input logic [CNT_W-1:0] count_o,
  input logic             rdy_o,
  input logic             pin_o
);
  AST_STOP_CLEARS_RDY: assert property (@(posedge clk) disable iff (rst)
    stop_rd |=> !rdy_o); // R7

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!rdy_o && pin_o)); // R10

  AST_TIMER_HIDES_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_mode) |=> (count_o == '0)); // R5

  AST_RDY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> $past(|src_tick)); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (count_o != '0 && !start_rd && !cfg_we) |=> $stable(count_o)); // R5

  AST_PIN_TRACKS_RDY: assert property (@(posedge clk) disable iff (rst)
    (count_o != '0) |-> (pin_o == !rdy_o)); // R9
endmodule

bind cdt_top cdt_top_chk #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .src_tick(src_tick), .cfg_we(cfg_we),
  .cfg_mode(cfg_mode), .start_rd(start_rd), .stop_rd(stop_rd),
  .count_o(count_o), .rdy_o(rdy_o), .pin_o(pin_o)
);

// File: tb/cdt_top_bench.sv
`timescale 1ns/1ps
module cdt_top_bench;
  localparam int CNT_W = 16;
  localparam int N_SRC = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = '0;
  logic        cfg_we = 1'b0, cfg_mode = 1'b0;
  logic [1:0]  cfg_src = '0;
  logic        pre_hi_we = 1'b0, pre_lo_we = 1'b0;
  logic [7:0]  pre_byte = '0;
  logic        start_rd = 1'b0, stop_rd = 1'b0;
  logic [15:0] count_o;
  logic        rdy_o, pin_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cdt_top #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_cdt_top (
    .clk(clk), .rst(rst), .src_tick(src_tick), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_src(cfg_src), .pre_hi_we(pre_hi_we),
    .pre_lo_we(pre_lo_we), .pre_byte(pre_byte), .start_rd(start_rd),
    .stop_rd(stop_rd), .count_o(count_o), .rdy_o(rdy_o), .pin_o(pin_o)
  );

  // Behavioural reference model
  int m_pre, m_cnt, m_src;
  bit m_cntmode, m_run, m_rdy, m_sq;

  always @(posedge clk) begin
    bit tk;
    tk = src_tick[m_src];
    if (rst) begin
      m_pre = 65535; m_cnt = 65535; m_src = 0;
      m_cntmode = 0; m_run = 0; m_rdy = 0; m_sq = 1;
    end else begin
      if (cfg_we) begin
        m_cntmode = cfg_mode; m_src = cfg_src; m_cnt = m_pre;
        m_run = 0; m_rdy = 0; m_sq = 1;
      end else if (!m_cntmode) begin
        if (tk) begin
          if (m_cnt <= 1) begin m_cnt = m_pre; m_sq = !m_sq; m_rdy = 1; end
          else m_cnt = m_cnt - 1;
        end
        if (stop_rd) m_rdy = 0;
      end else begin
        if (stop_rd) begin m_run = 0; m_rdy = 0; end
        else if (start_rd) begin m_cnt = m_pre; m_run = 1; end
        else if (m_run && tk) begin
          if (m_cnt == 1) m_rdy = 1;
          m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
        end
      end
      if (pre_hi_we) m_pre = (m_pre & 255) | (int'(pre_byte) << 8);
      if (pre_lo_we) m_pre = (m_pre & 65280) | int'(pre_byte);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int exp_cnt;
    bit exp_pin;
    exp_cnt = (m_cntmode && !m_run) ? m_cnt : 0;
    exp_pin = m_cntmode ? !m_rdy : m_sq;
    chk(int'(count_o) == exp_cnt, "R5 count_o vs model", count_o, exp_cnt);
    chk(rdy_o == m_rdy, "R4 rdy_o vs model", rdy_o, m_rdy);
    chk(pin_o == exp_pin, "R9 pin_o vs model", pin_o, exp_pin);
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (!rst) compare_model();
  endtask

  task automatic do_cycle(input logic [3:0] tk, input logic st, input logic sp);
    src_tick = tk; start_rd = st; stop_rd = sp;
    cfg_we = 0; pre_hi_we = 0; pre_lo_we = 0;
    cyc();
    start_rd = 0; stop_rd = 0; src_tick = 0;
  endtask

  task automatic wr_pre(input logic [7:0] hi, input logic [7:0] lo);
    pre_hi_we = 1; pre_byte = hi; cyc(); pre_hi_we = 0;
    pre_lo_we = 1; pre_byte = lo; cyc(); pre_lo_we = 0;
  endtask

  task automatic do_cfg(input logic md, input logic [1:0] src);
    cfg_we = 1; cfg_mode = md; cfg_src = src; cyc(); cfg_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int last;
    bit prev_pin;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk(count_o == 16'h0 && rdy_o == 0 && pin_o == 1, "R1 reset outputs",
        {count_o, rdy_o, pin_o}, 18'h1);

    // R2 / R10: preload 5, counter mode, source 0
    wr_pre(8'h00, 8'h05);
    do_cfg(1'b1, 2'd0);
    chk(count_o == 16'd5, "R2 R10 preload loaded by config", count_o, 5);

    // R3: start, hold ticks off, then three ticks, then stop
    do_cycle(4'h0, 1, 0);
    do_cycle(4'h0, 0, 0);
    chk(count_o == 16'd0, "R5 count hidden while running", count_o, 0);
    do_cycle(4'h0, 0, 0);
    repeat (3) do_cycle(4'h1, 0, 0);
    do_cycle(4'h0, 0, 1);
    chk(count_o == 16'd2, "R3 three decrements from 5", count_o, 2);

    // R4: terminal and wrap
    do_cycle(4'h1, 1, 0);
    repeat (5) do_cycle(4'h1, 0, 0);
    chk(rdy_o == 1, "R4 ready at terminal", rdy_o, 1);
    chk(pin_o == 0, "R9 pin low while ready in counter mode", pin_o, 0);
    do_cycle(4'h1, 0, 0);
    do_cycle(4'h0, 0, 1);
    chk(count_o == 16'hFFFF, "R4 wrap past zero", count_o, 16'hFFFF);
    chk(rdy_o == 0, "R7 stop clears ready", rdy_o, 0);

    // R8: source 2 only
    do_cfg(1'b1, 2'd2);
    do_cycle(4'h0, 1, 0);
    repeat (3) do_cycle(4'b1011, 0, 0);
    repeat (2) do_cycle(4'b0100, 0, 0);
    do_cycle(4'h0, 0, 1);
    chk(count_o == 16'd3, "R8 only selected source counts", count_o, 3);

    // R2 rewrite leaves count; R11 stop beats start
    wr_pre(8'h00, 8'h09);
    chk(count_o == 16'd3, "R2 rewrite does not touch count", count_o, 3);
    do_cycle(4'h0, 1, 1);
    chk(count_o == 16'd3, "R11 stop beats start", count_o, 3);
    wr_pre(8'h00, 8'h02);
    do_cycle(4'h0, 1, 0);
    do_cycle(4'b0100, 0, 0);
    do_cycle(4'b0100, 0, 1);
    chk(count_o == 16'd1 && rdy_o == 0, "R11 stop beats tick at terminal",
        {count_o, rdy_o}, 17'h2);

    // R6 / R7 / R10: timer mode, preload 3, tick every cycle
    wr_pre(8'h00, 8'h03);
    do_cfg(1'b0, 2'd0);
    chk(pin_o == 1 && rdy_o == 0 && count_o == 0, "R10 timer config state",
        {pin_o, rdy_o}, 2'b10);
    last = -1;
    prev_pin = pin_o;
    for (int i = 0; i < 24; i++) begin
      do_cycle(4'h1, (i == 5), (i == 11));
      if (pin_o != prev_pin) begin
        if (last >= 0) chk((i - last) == 3, "R6 half period equals preload", i - last, 3);
        last = i;
        prev_pin = pin_o;
      end
    end
    chk(last >= 0, "R6 square wave toggles", last, 0);
    do_cycle(4'h0, 0, 1);
    chk(rdy_o == 0, "R7 stop clears ready in timer mode", rdy_o, 0);
    chk(count_o == 16'd0, "R5 count hidden in timer mode", count_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule